// File: doc/BRIEF.md
# Minimum Supply Search Controller

This controller finds the lowest regulator code at which a delay-line copy of the chip's slowest path still completes within one clock period. It drives a voltage-identification code to the separate regulator that powers the copy. It waits for the supply to settle, and then runs a launch/capture test. In that test the launch flop is loaded with a constant one. The capture flop samples the far end of the delay line on the second test clock, after both flops leave reset.

A search begins at the lowest code and climbs one code at a time. The first code whose test captures a one becomes the answer. If even the highest code fails, the search still ends, but it raises an error and reports the highest code. The default range has 66 codes, from 0.45 V to 1.1 V in 10 mV steps. Code 0 is the lowest voltage, and each increment adds 10 mV. Software programs the settle time as a 16-bit cycle count.

Top module: `vmin_seeker`

## Requirements
- R1: Out of reset, `done_o` and `err_o` are 0, `vid_o` equals the lowest code (0), and `flop_rst_o` is 1.
- R2: A `start_i` pulse while idle or finished sets `vid_o` to the lowest code. Afterwards `vid_o` only moves up by exactly one per failed test.
- R3: After every change of `vid_o`, `flop_rst_o` stays 1 for at least `settle_i + 1` cycles before it is released.
- R4: Once `flop_rst_o` drops, the controller counts exactly two cycles with `tick_i` = 1. It then reads `capture_i` in the following cycle, where 1 means pass and 0 means fail.
- R5: On a pass, `done_o` rises, `err_o` is 0, and `code_o` and `vid_o` both hold the passing code.
- R6: If the highest code (65) fails, `done_o` rises with `err_o` = 1 and `code_o` = 65.
- R7: A `start_i` pulse during a search has no effect: the code sequence and the final result are unchanged.
- R8: `done_o`, `code_o` and `vid_o` stay constant after completion until the next `start_i`. `flop_rst_o` is 1 whenever no test is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new search (pulse) |
| settle_i | input | 16 | Settle wait in cycles after each code change |
| tick_i | input | 1 | Test clock enable seen by the replica flops |
| capture_i | input | 1 | Capture flop output of the replica |
| vid_o | output | 7 | Supply code for the replica regulator |
| flop_rst_o | output | 1 | Reset for the launch and capture flops |
| done_o | output | 1 | Search finished |
| err_o | output | 1 | No code passed |
| code_o | output | 7 | Result code |

## Verification
The replica threshold is drawn at random, with directed cases at the lowest code, at the highest code and above the range. Together these separate an immediate pass, a mid-range pass, a last-code pass and the error exit.

The tick spacing and the settle count vary from search to search. This shows whether the decision really waits for two ticks and whether the settle wait tracks the programmed count.

Extra start pulses in mid-search reveal any restart. A model of the replica that captures a one only on its second tick exposes a decision taken after one tick or after three.

// File: rtl/vmin_pkg.sv
package vmin_pkg;
   typedef enum logic [1:0] {
      SK_IDLE   = 2'd0,
      SK_SETTLE = 2'd1,
      SK_TEST   = 2'd2,
      SK_DONE   = 2'd3
   } seek_state_t;
endpackage

// File: rtl/vmin_settle_timer.sv
module vmin_settle_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] remain_q;

   if (CNT_W < 1) begin : g_bad_width
      $error("settle counter width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= '0;
      else if (load_i)
         remain_q <= load_val_i;
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   assign expired_o = (remain_q == '0);

   assert_timer_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && remain_q != '0) |=> (remain_q == $past(remain_q) - 1'b1));
endmodule

// File: rtl/vmin_tick_counter.sv
module vmin_tick_counter #(
   parameter int TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   output logic reached_o
);
   localparam int TW = $clog2(TICKS + 1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("tick count must be at least one");
   end

   if (TICKS == 1) begin : g_single
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       seen_q <= 1'b0;
         else if (clear_i) seen_q <= 1'b0;
         else if (tick_i)  seen_q <= 1'b1;
      end
      assign reached_o = seen_q;
   end else begin : g_multi
      logic [TW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clear_i)
            cnt_q <= '0;
         else if (tick_i && cnt_q != TW'(TICKS))
            cnt_q <= cnt_q + 1'b1;
      end
      assign reached_o = (cnt_q == TW'(TICKS));

      assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= TW'(TICKS));
      assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!clear_i && !tick_i) |=> $stable(cnt_q));
   end
endmodule

// File: rtl/vmin_code_stepper.sv
module vmin_code_stepper #(
   parameter int CODE_W   = 7,
   parameter int CODE_MIN = 0,
   parameter int CODE_MAX = 65
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              step_i,
   output logic [CODE_W-1:0] code_o,
   output logic              at_top_o
);
   localparam logic [CODE_W-1:0] LO = CODE_W'(CODE_MIN);
   localparam logic [CODE_W-1:0] HI = CODE_W'(CODE_MAX);

   if (CODE_MAX >= (1 << CODE_W) || CODE_MIN > CODE_MAX || CODE_MIN < 0) begin : g_bad_range
      $error("code range does not fit the code width");
   end

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= LO;
      else if (init_i)
         code_q <= LO;
      else if (step_i && code_q != HI)
         code_q <= code_q + 1'b1;
   end

   assign code_o   = code_q;
   assign at_top_o = (code_q == HI);

   assert_code_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> (code_q == $past(code_q) + 1'b1) || (code_q == LO));
   assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      code_q >= LO && code_q <= HI);
endmodule

// File: rtl/vmin_seeker.sv
module vmin_seeker #(
   parameter int CODE_W   = 7,
   parameter int CODE_MIN = 0,
   parameter int CODE_MAX = 65,
   parameter int SETTLE_W = 16,
   parameter int TICKS    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                tick_i,
   input  logic                capture_i,
   output logic [CODE_W-1:0]   vid_o,
   output logic                flop_rst_o,
   output logic                done_o,
   output logic                err_o,
   output logic [CODE_W-1:0]   code_o
);
   import vmin_pkg::*;

   localparam logic [CODE_W-1:0] HI = CODE_W'(CODE_MAX);

   seek_state_t       state_q, state_d;
   logic              t_load, t_expired;
   logic              k_clear, k_reached;
   logic              c_init, c_step, c_top;
   logic              done_q, err_q;
   logic [CODE_W-1:0] res_q;
   logic              accept, judge, pass, fail_last, fail_more;

   assign accept    = start_i && (state_q == SK_IDLE || state_q == SK_DONE);
   assign judge     = (state_q == SK_TEST) && k_reached;
   assign pass      = judge && capture_i;
   assign fail_last = judge && !capture_i && c_top;
   assign fail_more = judge && !capture_i && !c_top;

   assign t_load  = accept || fail_more;
   assign c_init  = accept;
   assign c_step  = fail_more;
   assign k_clear = (state_q != SK_TEST);

   vmin_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (t_load),
      .load_val_i(settle_i),
      .expired_o (t_expired)
   );

   vmin_tick_counter #(.TICKS(TICKS)) u_ticks (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (k_clear),
      .tick_i   (tick_i),
      .reached_o(k_reached)
   );

   vmin_code_stepper #(
      .CODE_W  (CODE_W),
      .CODE_MIN(CODE_MIN),
      .CODE_MAX(CODE_MAX)
   ) u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (c_init),
      .step_i  (c_step),
      .code_o  (vid_o),
      .at_top_o(c_top)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SK_IDLE, SK_DONE: if (accept) state_d = SK_SETTLE;
         SK_SETTLE:        if (t_expired) state_d = SK_TEST;
         SK_TEST: begin
            if (pass || fail_last) state_d = SK_DONE;
            else if (fail_more)    state_d = SK_SETTLE;
         end
         default: state_d = SK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SK_IDLE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         res_q   <= CODE_W'(CODE_MIN);
      end else begin
         state_q <= state_d;
         if (accept) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (pass) begin
            done_q <= 1'b1;
            res_q  <= vid_o;
         end else if (fail_last) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            res_q  <= vid_o;
         end
      end
   end

   assign flop_rst_o = (state_q != SK_TEST);
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign code_o     = res_q;

   assert_vid_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vid_o) |-> flop_rst_o);
   assert_pass_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (code_o == vid_o));
   assert_err_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (code_o == HI) && done_o);
   assert_done_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> flop_rst_o);
   assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == SK_SETTLE) |=> (state_q != SK_IDLE));
endmodule

// File: tb/vmin_seeker_test.sv
module vmin_seeker_test;
   localparam int MAXC = 65;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [15:0] settle_i = 16'd0;
   logic       tick_i = 1'b0;
   logic       capture_i;
   logic [6:0] vid_o, code_o;
   logic       flop_rst_o, done_o, err_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int thr = 0;
   int period = 1;
   int pcnt = 0;
   logic launch_q = 1'b0, cap_q = 1'b0;
   logic [6:0] prev_vid = 7'd0;
   logic prev_rst = 1'b1;
   int rst_run = 0;
   int steps = 0;
   bit mon_on = 1'b0;

   vmin_seeker uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
      .tick_i(tick_i), .capture_i(capture_i), .vid_o(vid_o),
      .flop_rst_o(flop_rst_o), .done_o(done_o), .err_o(err_o), .code_o(code_o)
   );

   always #10 clk = ~clk;

   // behavioural replica: launch flop fed by one, capture sees it only if the delay fits
   always_ff @(posedge clk) begin
      if (flop_rst_o) begin
         launch_q <= 1'b0;
         cap_q    <= 1'b0;
      end else if (tick_i) begin
         launch_q <= 1'b1;
         cap_q    <= launch_q && (int'(vid_o) >= thr);
      end
   end
   assign capture_i = cap_q;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_code(input int t);
      if (t <= 0) return 0;
      if (t > MAXC) return MAXC;
      return t;
   endfunction

   // tick generator and protocol monitor, both on the falling edge
   always @(negedge clk) begin
      cyc++;
      pcnt++;
      if (pcnt >= period) begin
         pcnt = 0;
         tick_i <= 1'b1;
      end else begin
         tick_i <= 1'b0;
      end
      if (mon_on) begin
         if (vid_o != prev_vid) begin
            // R2: only +1 steps during a search
            check(vid_o == prev_vid + 7'd1, "R2", int'(vid_o), int'(prev_vid) + 1);
            steps++;
            rst_run = 0;
         end
         if (flop_rst_o) rst_run++;
         if (prev_rst && !flop_rst_o)
            check(rst_run >= int'(settle_i) + 1, "R3", rst_run, int'(settle_i) + 1);
      end
      prev_vid = vid_o;
      prev_rst = flop_rst_o;
      if (cyc == 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic run_search(input int t, input int s, input int per, input bit poke);
      int e;
      int n;
      e = exp_code(t);
      @(negedge clk);
      thr = t;
      settle_i = 16'(s);
      period = per;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: first code is the lowest
      check(vid_o == 7'd0 && !done_o, "R2", int'(vid_o), 0);
      prev_vid = vid_o;
      steps = 0;
      mon_on = 1'b1;
      n = 0;
      while (!done_o && n < 40000) begin
         @(negedge clk);
         n++;
         if (poke && (n == 7 || n == 40)) start_i = 1'b1;   // R7: ignored
         else start_i = 1'b0;
      end
      start_i = 1'b0;
      mon_on = 1'b0;
      check(done_o, "R4", int'(done_o), 1);
      if (t > MAXC) begin
         check(err_o, "R6", int'(err_o), 1);
         check(code_o == 7'(MAXC), "R6", int'(code_o), MAXC);
      end else begin
         check(!err_o, "R5", int'(err_o), 0);
         check(code_o == 7'(e) && vid_o == 7'(e), "R5", int'(code_o), e);
      end
      check(steps == e, poke ? "R7" : "R2", steps, e);
      repeat (6) @(negedge clk);
      check(done_o && code_o == 7'(e) && vid_o == 7'(e) && flop_rst_o, "R8", int'(code_o), e);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!done_o && !err_o && vid_o == 7'd0 && flop_rst_o, "R1", int'(vid_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!done_o && !err_o && vid_o == 7'd0 && flop_rst_o, "R1", int'(done_o), 0);
      // directed corners
      run_search(0, 0, 1, 1'b0);       // immediate pass, back-to-back ticks
      run_search(MAXC, 2, 3, 1'b0);    // last code passes
      run_search(MAXC + 3, 0, 2, 1'b0);// nothing passes
      run_search(20, 5, 4, 1'b1);      // start pokes while busy
      run_search(1, 17, 1, 1'b0);
      // random mix
      for (int i = 0; i < 14; i++)
         run_search(int'($urandom_range(0, 70)), int'($urandom_range(0, 20)),
                    int'($urandom_range(1, 4)), i[0]);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule